// File: doc/BRIEF.md
# I2C Master Read Controller

This block is a bus master that reads bytes from an I2C slave. The host gives it a 7-bit slave address and one-cycle command pulses: one asks for a bus start and the other asks for a bus stop. The block then drives the bus with open-drain clock and data pins. It sends the address with the direction bit set to read, checks the slave's acknowledge, and then clocks in data bytes one after another. Each received byte goes into a one-entry holding register and raises a ready flag. The host clears that flag by pulsing a read strobe, and an external DMA channel can use the same flag as its receive request.

A transfer has no byte count. The host ends it by requesting stop or repeated start, and the byte that is completing when that request is noticed becomes the last one. The master sends a not-acknowledge after that byte and then produces the requested bus condition. If the host has not drained the holding register, the block stops with the clock held low just before the final bit of the next byte. This throttles the slave until the register is read.

If the slave does not acknowledge its address, the block sets a sticky not-acknowledge flag, sends a stop and returns to idle. The next start request clears the flag.

Top module: `i2c_rd_master`

## Requirements
- R1: After reset, neither bus pin is pulled low (`scl_oe`=0, `sda_oe`=0), and `rx_ready`, `nack_flag` and `busy` are all 0.
- R2: A start request in idle produces a START condition (SDA falls while SCL is high). The slave then receives the address byte {slv_addr[6:0], 1}, most significant bit first, where the trailing 1 is the read direction bit.
- R3: If SDA is high when sampled on the ninth clock after the address, `nack_flag` becomes 1. No data byte is clocked, a STOP follows, `busy` returns to 0 and `rx_ready` is unchanged. The next start request clears `nack_flag` to 0.
- R4: Each data byte is shifted in most significant bit first and placed in `rx_data` with `rx_ready`=1. A one-cycle `rd_en` clears `rx_ready`. A held byte is never overwritten.
- R5: The master pulls SDA low (ACK, bit value 0) on the ninth clock of every data byte that is not the last one.
- R6: A start request with stop asserted in the same cycle reads exactly one byte, leaves SDA high (NACK, bit value 1) on its ninth clock, and then issues STOP.
- R7: A stop request that arrives after a byte has been placed in the holding register makes the byte after it the last one. That byte is NACKed, followed by STOP, and no further byte is read.
- R8: A start request made during a transfer makes the following byte the last one. That byte is NACKed and followed by a repeated START with no STOP in between, and then by a new address phase and further reads.
- R9: While `rx_ready`=1, the next byte halts with SCL held low before its eighth data bit is clocked. No SCL rising edge occurs until `rd_en` drains the register, and the byte then completes with correct data.
- R10: A stop request issued while the clock is halted for a full holding register applies to the halted byte. That byte is NACKed and followed by STOP.
- R11: Outside of START and STOP, SDA changes only while SCL is low. The only data-line edges seen while SCL is high are the requested START, repeated START and STOP conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle request: START when idle, repeated START when busy |
| cmd_stop | input | 1 | One-cycle request to end the transfer with STOP |
| slv_addr | input | 7 | Slave address, captured at each start |
| quarter_div | input | DIV_W | System clocks per quarter bit, minus one |
| rd_en | input | 1 | Read strobe that drains the holding register |
| rx_data | output | 8 | Holding register contents |
| rx_ready | output | 1 | Holding register full; also the DMA receive request |
| nack_flag | output | 1 | Sticky flag: address not acknowledged |
| busy | output | 1 | Transfer in progress |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The hardest state to reach is the clock halt. The holding register must still be full at the moment the following byte reaches its final bit, and a stop request may have to land inside that halt. The bench's reading process has a programmable delay. Setting that delay far longer than a byte time leaves the first byte unread, so the second byte runs into the halt. The bench then watches the clock line for missing rising edges and issues stop requests at chosen points: either before the read or only after the next byte has arrived.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_AACK,
        ST_DATA,
        ST_DACK,
        ST_STOP
    } rd_state_e;

    typedef struct packed {
        rd_state_e              st;
        logic [1:0]             qtr;
        logic [BIT_IDX_W-1:0]   bitn;
        logic [ADDR_W-1:0]      addr;
        logic [BYTE_W-1:0]      shreg;
        logic                   last;
        logic                   stop_pend;
        logic                   rs_pend;
        logic                   nack;
        logic                   scl_lo;
        logic                   sda_lo;
    } rd_ctl_t;
endpackage

// File: rtl/i2c_rd_sync.sv
module i2c_rd_sync #(
    parameter int W = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_rd_tick.sv
module i2c_rd_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             freeze,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (!freeze) begin
            if (cnt_q >= div) begin
                tick  = 1'b1;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_rd_hold.sv
module i2c_rd_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          rd,
    output logic [DW-1:0] dout,
    output logic          ready
);
    logic [DW-1:0] data_d, data_q;
    logic          ready_d, ready_q;

    always_comb begin
        data_d  = data_q;
        ready_d = ready_q;
        if (rd)   ready_d = 1'b0;
        if (load) begin
            data_d  = din;
            ready_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            ready_q <= 1'b0;
        end else begin
            data_q  <= data_d;
            ready_q <= ready_d;
        end
    end

    assign dout  = data_q;
    assign ready = ready_q;

    // R4: the receive side never loads into a full register
    a_r4_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !ready_q);
    // R4: a read strobe drains the register
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !load && ready_q) |=> !ready_q);
    // R4: a loaded byte appears with the ready flag
    a_r4_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ready_q && data_q == $past(din)));
endmodule

// File: rtl/i2c_rd_fsm.sv
module i2c_rd_fsm
    import i2c_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic [ADDR_W-1:0] slv_addr,
    input  logic              sda_s,
    input  logic              rx_full,
    output logic              busy,
    output logic              stall,
    output logic              scl_lo,
    output logic              sda_lo,
    output logic              nack,
    output logic              load,
    output logic [BYTE_W-1:0] ld_data
);
    localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(BYTE_W - 1);

    rd_ctl_t c_d, c_q;
    logic [BYTE_W-1:0] frame;

    always_comb begin
        c_d     = c_q;
        load    = 1'b0;
        ld_data = {c_q.shreg[BYTE_W-2:0], sda_s};
        frame   = {c_q.addr, 1'b1};
        stall   = (c_q.st == ST_DATA) && (c_q.bitn == LAST_BIT) &&
                  (c_q.qtr == 2'd1) && rx_full;

        if (c_q.st == ST_IDLE) begin
            if (cmd_start) begin
                c_d.st        = ST_START;
                c_d.qtr       = 2'd0;
                c_d.addr      = slv_addr;
                c_d.nack      = 1'b0;
                c_d.stop_pend = cmd_stop;
                c_d.rs_pend   = 1'b0;
                c_d.last      = 1'b0;
            end
        end else begin
            if (tick) begin
                if (c_q.qtr != 2'd3) begin
                    c_d.qtr = c_q.qtr + 2'd1;
                    case (c_q.qtr)
                        2'd0: begin
                            case (c_q.st)
                                ST_START: c_d.sda_lo = 1'b0;
                                ST_ADDR:  c_d.sda_lo = !frame[LAST_BIT - c_q.bitn];
                                ST_DACK:  c_d.sda_lo = !c_q.last;
                                ST_STOP:  c_d.sda_lo = 1'b1;
                                default:  c_d.sda_lo = 1'b0;
                            endcase
                        end
                        2'd1: c_d.scl_lo = 1'b0;
                        default: begin
                            case (c_q.st)
                                ST_START: c_d.sda_lo = 1'b1;
                                ST_STOP:  c_d.sda_lo = 1'b0;
                                ST_AACK:  if (sda_s) c_d.nack = 1'b1;
                                ST_DATA: begin
                                    c_d.shreg = ld_data;
                                    if (c_q.bitn == LAST_BIT) begin
                                        load     = 1'b1;
                                        c_d.last = c_q.stop_pend | c_q.rs_pend;
                                    end
                                end
                                default: ;
                            endcase
                        end
                    endcase
                end else begin
                    c_d.qtr    = 2'd0;
                    c_d.scl_lo = 1'b1;
                    case (c_q.st)
                        ST_START: begin
                            c_d.st   = ST_ADDR;
                            c_d.bitn = '0;
                        end
                        ST_ADDR: begin
                            if (c_q.bitn == LAST_BIT) begin
                                c_d.st   = ST_AACK;
                                c_d.bitn = '0;
                            end else begin
                                c_d.bitn = c_q.bitn + 1'b1;
                            end
                        end
                        ST_AACK: begin
                            if (c_q.nack) begin
                                c_d.st        = ST_STOP;
                                c_d.stop_pend = 1'b0;
                                c_d.rs_pend   = 1'b0;
                            end else begin
                                c_d.st   = ST_DATA;
                                c_d.bitn = '0;
                            end
                        end
                        ST_DATA: begin
                            if (c_q.bitn == LAST_BIT) c_d.st = ST_DACK;
                            else                      c_d.bitn = c_q.bitn + 1'b1;
                        end
                        ST_DACK: begin
                            if (!c_q.last) begin
                                c_d.st   = ST_DATA;
                                c_d.bitn = '0;
                            end else begin
                                c_d.st        = c_q.rs_pend ? ST_START : ST_STOP;
                                c_d.addr      = slv_addr;
                                c_d.last      = 1'b0;
                                c_d.stop_pend = 1'b0;
                                c_d.rs_pend   = 1'b0;
                            end
                        end
                        default: begin
                            c_d.st     = ST_IDLE;
                            c_d.scl_lo = 1'b0;
                        end
                    endcase
                end
            end
            if (cmd_stop)  c_d.stop_pend = 1'b1;
            if (cmd_start) c_d.rs_pend   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, default: '0};
        else        c_q <= c_d;
    end

    assign busy   = (c_q.st != ST_IDLE);
    assign scl_lo = c_q.scl_lo;
    assign sda_lo = c_q.sda_lo;
    assign nack   = c_q.nack;

    // R9: a halted byte keeps SCL pulled low
    a_r9_stall_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> c_q.scl_lo);
    // R9: the quarter sequencer does not move while halted
    a_r9_stall_holds_position: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (c_q.st == ST_DATA && c_q.bitn == LAST_BIT && c_q.qtr == 2'd1));
    // R11: SDA is steady through an SCL high phase of any bit
    a_r11_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_q.scl_lo && $past(!c_q.scl_lo) && $past(c_q.st) == c_q.st &&
         c_q.st inside {ST_ADDR, ST_AACK, ST_DATA, ST_DACK}) |-> $stable(c_q.sda_lo));
    // R3: the not-acknowledge flag rises only from the address acknowledge bit
    a_r3_nack_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.nack) |-> $past(c_q.st) == ST_AACK);
endmodule

// File: rtl/i2c_rd_master.sv
module i2c_rd_master
    import i2c_rd_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic [ADDR_W-1:0] slv_addr,
    input  logic [DIV_W-1:0]  quarter_div,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              nack_flag,
    output logic              busy,
    output logic              scl_oe,
    input  logic              sda_i,
    output logic              sda_oe
);
    logic              sda_s;
    logic              tick_w;
    logic              stall_w;
    logic              busy_w;
    logic              load_w;
    logic [BYTE_W-1:0] ld_data_w;
    logic              ready_w;

    i2c_rd_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sda_i),
        .dout  (sda_s)
    );

    i2c_rd_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy_w),
        .freeze (stall_w),
        .div    (quarter_div),
        .tick   (tick_w)
    );

    i2c_rd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_w),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .slv_addr  (slv_addr),
        .sda_s     (sda_s),
        .rx_full   (ready_w),
        .busy      (busy_w),
        .stall     (stall_w),
        .scl_lo    (scl_oe),
        .sda_lo    (sda_oe),
        .nack      (nack_flag),
        .load      (load_w),
        .ld_data   (ld_data_w)
    );

    i2c_rd_hold #(.DW(BYTE_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_w),
        .din   (ld_data_w),
        .rd    (rd_en),
        .dout  (rx_data),
        .ready (ready_w)
    );

    assign rx_ready = ready_w;
    assign busy     = busy_w;
endmodule

// File: tb/tb_i2c_rd_master.sv
module tb_i2c_rd_master;
    localparam logic [6:0] SLV = 7'h52;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 1'b0, cmd_stop = 1'b0, rd_en = 1'b0;
    logic [6:0] slv_addr = SLV;
    logic [15:0] quarter_div = 16'd3;
    logic [7:0] rx_data;
    logic rx_ready, nack_flag, busy, scl_oe, sda_oe;
    logic s_drive = 1'b0;
    wire scl_line = ~scl_oe;
    wire sda_line = ~(sda_oe | s_drive);

    always #10 clk = ~clk;

    i2c_rd_master dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .slv_addr(slv_addr), .quarter_div(quarter_div), .rd_en(rd_en),
        .rx_data(rx_data), .rx_ready(rx_ready), .nack_flag(nack_flag), .busy(busy),
        .scl_oe(scl_oe), .sda_i(sda_line), .sda_oe(sda_oe)
    );

    int checks = 0, errors = 0;
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int k);
        return 8'(k * 37 + 11);
    endfunction

    // slave model
    int starts = 0, stops = 0, scl_rises = 0, abit = 0, dbit = 0, sidx = 0;
    bit active = 0, data_ph = 0;
    logic [7:0] ash = '0, last_addr = '0, cur = '0;
    bit ack_q[$];

    always @(posedge scl_line) if (rst_n) scl_rises++;
    always @(negedge sda_line) if (rst_n && scl_line === 1'b1) begin
        starts++; active = 1; data_ph = 0; abit = 0; s_drive = 0;
    end
    always @(posedge sda_line) if (rst_n && scl_line === 1'b1) begin
        stops++; active = 0; s_drive = 0;
    end
    always @(posedge scl_line) if (active) begin
        if (!data_ph) begin
            if (abit < 8) begin ash = {ash[6:0], sda_line}; abit++; end
        end else if (dbit == 9) begin
            ack_q.push_back(sda_line);
            if (sda_line) active = 0; else dbit = 0;
        end
    end
    always @(negedge scl_line) if (active) begin
        if (!data_ph) begin
            if (abit == 8) begin
                last_addr = ash;
                if (ash == {SLV, 1'b1}) begin s_drive = 1; abit = 9; end
                else active = 0;
            end else if (abit == 9) begin
                data_ph = 1; dbit = 0;
            end
        end
        if (data_ph) begin
            if (dbit == 0) begin cur = pat(sidx); sidx++; end
            if (dbit < 8) begin s_drive = ~cur[7 - dbit]; dbit++; end
            else if (dbit == 8) begin s_drive = 0; dbit = 9; end
        end
    end

    // scoreboard
    logic [7:0] exp_q[$];
    int exp_idx = 0, rx_cnt = 0, rd_delay = 2;

    task automatic push_exp(input int n);
        for (int i = 0; i < n; i++) begin exp_q.push_back(pat(exp_idx)); exp_idx++; end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (rx_ready) begin
                rx_cnt++;
                repeat (rd_delay) @(negedge clk);
                if (exp_q.size() == 0) chk(0, "R4 unexpected byte", rx_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rx_data == e, "R4 data", rx_data, e);
                end
                rd_en = 1'b1;
                @(negedge clk);
                rd_en = 1'b0;
            end
        end
    end

    task automatic pulse_start(input bit with_stop);
        @(negedge clk); cmd_start = 1'b1; cmd_stop = with_stop;
        @(negedge clk); cmd_start = 1'b0; cmd_stop = 1'b0;
    endtask
    task automatic pulse_stop();
        @(negedge clk); cmd_stop = 1'b1;
        @(negedge clk); cmd_stop = 1'b0;
    endtask
    task automatic wait_rx(input int target);
        while (rx_cnt < target) @(negedge clk);
    endtask
    task automatic wait_done();
        @(negedge clk);
        while (busy) @(negedge clk);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask
    task automatic chk_acks(input string tag, input int n, input int nack_pos_mask);
        chk(ack_q.size() == n, {tag, " ack count"}, ack_q.size(), n);
        for (int i = 0; i < n && i < ack_q.size(); i++)
            chk(ack_q[i] == nack_pos_mask[i], {tag, " ack bit"}, ack_q[i], nack_pos_mask[i]);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual busy=%0d expected idle", busy);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s0, p0, b0, r0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(scl_oe == 0 && sda_oe == 0, "R1 pins released", {scl_oe, sda_oe}, 0);
        chk(rx_ready == 0 && nack_flag == 0 && busy == 0, "R1 flags",
            {rx_ready, nack_flag, busy}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R6 one-byte read, R2 address frame
        ack_q.delete(); s0 = starts; p0 = stops; b0 = rx_cnt;
        push_exp(1); pulse_start(1); wait_done();
        chk(last_addr == {SLV, 1'b1}, "R2 address byte", last_addr, {SLV, 1'b1});
        chk(rx_cnt - b0 == 1, "R6 byte count", rx_cnt - b0, 1);
        chk_acks("R6", 1, 'b1);
        chk(starts - s0 == 1 && stops - p0 == 1, "R11 start/stop events",
            (starts - s0) * 16 + (stops - p0), 17);

        // R7 four-byte read, R5 acks
        ack_q.delete(); s0 = starts; p0 = stops; b0 = rx_cnt;
        push_exp(4); pulse_start(0); wait_rx(b0 + 3); pulse_stop(); wait_done();
        chk(rx_cnt - b0 == 4, "R7 byte count", rx_cnt - b0, 4);
        chk_acks("R5 R7", 4, 'b1000);
        chk(starts - s0 == 1 && stops - p0 == 1, "R11 start/stop events",
            (starts - s0) * 16 + (stops - p0), 17);

        // R3 address not acknowledged
        ack_q.delete(); s0 = starts; p0 = stops; b0 = rx_cnt; r0 = scl_rises;
        slv_addr = 7'h13; pulse_start(0); wait_done();
        chk(nack_flag == 1, "R3 flag set", nack_flag, 1);
        chk(rx_ready == 0 && rx_cnt == b0, "R3 no data", rx_cnt - b0, 0);
        chk(scl_rises - r0 == 10, "R3 clock pulses", scl_rises - r0, 10);
        chk(stops - p0 == 1 && busy == 0, "R3 stop and idle", stops - p0, 1);

        // R8 repeated start, R3 flag cleared
        ack_q.delete(); s0 = starts; p0 = stops; b0 = rx_cnt;
        slv_addr = SLV; push_exp(4); pulse_start(0);
        chk(nack_flag == 0, "R3 flag cleared", nack_flag, 0);
        wait_rx(b0 + 1); pulse_start(0);
        wait_rx(b0 + 3); pulse_stop(); wait_done();
        chk_acks("R8", 4, 'b1010);
        chk(starts - s0 == 2 && stops - p0 == 1, "R8 repeated start",
            (starts - s0) * 16 + (stops - p0), 33);
        chk(last_addr == {SLV, 1'b1}, "R8 second address", last_addr, {SLV, 1'b1});

        // R9 halt while holding register full
        ack_q.delete(); s0 = starts; p0 = stops; b0 = rx_cnt;
        rd_delay = 400; push_exp(3); pulse_start(0);
        wait_rx(b0 + 1);
        repeat (200) @(negedge clk);
        r0 = scl_rises;
        chk(scl_line == 0, "R9 clock held low", scl_line, 0);
        repeat (100) @(negedge clk);
        chk(scl_rises == r0 && scl_line == 0, "R9 no clock edges", scl_rises - r0, 0);
        wait_rx(b0 + 2); pulse_stop(); wait_done();
        chk_acks("R9", 3, 'b100);
        chk(stops - p0 == 1, "R9 stop", stops - p0, 1);

        // R10 stop while halted
        ack_q.delete(); p0 = stops; b0 = rx_cnt;
        push_exp(2); pulse_start(0);
        wait_rx(b0 + 1);
        repeat (200) @(negedge clk);
        chk(scl_line == 0, "R10 halted before stop", scl_line, 0);
        pulse_stop(); wait_done();
        chk(rx_cnt - b0 == 2, "R10 byte count", rx_cnt - b0, 2);
        chk_acks("R10", 2, 'b10);
        chk(stops - p0 == 1 && busy == 0, "R10 stop", stops - p0, 1);

        chk(exp_q.size() == 0, "R4 all bytes seen", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule